// File: doc/BRIEF.md
# Bit-Matrix Transpose and Column-Grouping Permuter

This block rearranges the bits of a square bit matrix of DIM by DIM bits (16 by 16 by default), presented as one flat word. Row r of the matrix sits in bits DIM*r up to DIM*r+DIM-1. Within a row, column 0 is the least significant bit. The bit index of element (r, c) is therefore DIM*r + c.

A mode input selects one of two permutations. Mode 0 gives the exact transpose. Mode 1 gives a cheaper column-grouping permutation, which moves every input column into a single output row. The bits inside that row come out in a rotated order. Downstream logic that needs only the bits of each column, and not their strict order, can use mode 1. Examples are counting the ones per column or decoding one-hot masks.

The output word is registered. It comes with a valid strobe that rises one cycle after a valid input.

Top module: `bitmat_permuter`

## Requirements
- R1: While reset is asserted (rst_n = 0), and after it until the first valid input, out_valid is 0 and out_data is all zeros.
- R2: out_valid is 1 in the cycle after in_valid = 1 and is 0 in the cycle after in_valid = 0. out_data changes only in the cycle after a valid input and otherwise keeps its value.
- R3: With mode = 0, output bit DIM*c + r equals input bit DIM*r + c for every r and c.
- R4: With mode = 1, every input bit appears exactly once in the output. Input column c lands entirely in output row ((8 - c mod 8) mod 8) + 8*(c div 8). For the default DIM = 16 this is row 0 for column 0, row 7 for column 1, and row 8 for column 8.
- R5: The first mode-1 stage exchanges the top-right 8x8 quadrant with the bottom-left one and leaves the two diagonal quadrants in place. Element (r, c) with exactly one of r and c at 8 or above moves to (r xor 8, c xor 8).
- R6: The second mode-1 stage rotates each row left by its row index. The element in column c of row r moves to column (c + r) mod 16.
- R7: The third mode-1 stage works inside each 8x8 quadrant separately. The element at quadrant row p of column c moves to quadrant row (p - (c mod 8)) mod 8. It is built from three conditional stages that shift by 4, 2 and 1, and nothing crosses a quadrant boundary.
- R8: Applying mode 0 twice returns the original matrix.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input word is valid this cycle |
| mode | input | 1 | 0: transpose, 1: column-grouping permutation |
| in_data | input | DIM*DIM | Input matrix, row r at bits DIM*r and up |
| out_valid | output | 1 | Registered result is new this cycle |
| out_data | output | DIM*DIM | Registered permuted matrix |

## Verification
The clocked properties assume that mode and in_data are steady and meaningful whenever in_valid is high. They compare the registered output with the inputs captured one cycle earlier. The bench drives every input on the falling edge and holds it for a full cycle around the capturing edge, so that assumption always holds. It returns in_valid to 0 between operations, so the hold and idle rules of R2 are seen between every pair of results. Inputs are unconstrained beyond that: single bits, whole columns, and pseudo-random dense words all enter through the same path.

// File: rtl/bitmat_pkg.sv
package bitmat_pkg;

  // Index whose bits a and b are exchanged.
  function automatic int xchg_bits(input int idx, input int a, input int b);
    int ba;
    int bb;
    ba = (idx >> a) & 1;
    bb = (idx >> b) & 1;
    return (ba == bb) ? idx : (idx ^ ((1 << a) | (1 << b)));
  endfunction

  // Source column feeding column c of row r after a left rotate by r.
  function automatic int rowrot_src(input int r, input int c, input int dim);
    return (c - r + dim) % dim;
  endfunction

  // Source row feeding row r when a column shifts up by sh inside its half.
  function automatic int quadrot_src(input int r, input int sh, input int half);
    return (r / half) * half + ((r % half) + sh) % half;
  endfunction

endpackage

// File: rtl/bitmat_idx_swap.sv
module bitmat_idx_swap #(
  parameter int BITS = 256,
  parameter int A    = 0,
  parameter int B    = 4
) (
  input  logic [BITS-1:0] din,
  output logic [BITS-1:0] dout
);
  for (genvar i = 0; i < BITS; i++) begin : g_bit
    localparam int SRC = bitmat_pkg::xchg_bits(i, A, B);
    assign dout[i] = din[SRC];
  end
endmodule

// File: rtl/bitmat_row_rot.sv
module bitmat_row_rot #(
  parameter int DIM = 16
) (
  input  logic [DIM*DIM-1:0] din,
  output logic [DIM*DIM-1:0] dout
);
  for (genvar r = 0; r < DIM; r++) begin : g_row
    for (genvar c = 0; c < DIM; c++) begin : g_col
      localparam int SC = bitmat_pkg::rowrot_src(r, c, DIM);
      assign dout[r*DIM+c] = din[r*DIM+SC];
    end
  end
endmodule

// File: rtl/bitmat_col_stage.sv
module bitmat_col_stage #(
  parameter int DIM = 16,
  parameter int SEL = 0
) (
  input  logic [DIM*DIM-1:0] din,
  output logic [DIM*DIM-1:0] dout
);
  localparam int HALF = DIM / 2;
  localparam int SH   = 1 << SEL;

  for (genvar r = 0; r < DIM; r++) begin : g_row
    for (genvar c = 0; c < DIM; c++) begin : g_col
      if (((c >> SEL) & 1) == 1) begin : g_move
        localparam int SR = bitmat_pkg::quadrot_src(r, SH, HALF);
        assign dout[r*DIM+c] = din[SR*DIM+c];
      end else begin : g_keep
        assign dout[r*DIM+c] = din[r*DIM+c];
      end
    end
  end
endmodule

// File: rtl/bitmat_permuter.sv
module bitmat_permuter #(
  parameter int DIM = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic               mode,
  input  logic [DIM*DIM-1:0] in_data,
  output logic               out_valid,
  output logic [DIM*DIM-1:0] out_data
);
  localparam int LOGD = $clog2(DIM);
  localparam int BITS = DIM * DIM;
  localparam int LOGH = LOGD - 1;

  // Transpose: one index-bit exchange per column-index bit.
  logic [BITS-1:0] xp_chain [0:LOGD];
  assign xp_chain[0] = in_data;
  for (genvar k = 0; k < LOGD; k++) begin : g_xround
    bitmat_idx_swap #(.BITS(BITS), .A(k), .B(k + LOGD)) u_round (
      .din (xp_chain[k]),
      .dout(xp_chain[k+1])
    );
  end

  // Column grouping: quadrant exchange, row rotate, column rotate.
  logic [BITS-1:0] qswap;
  logic [BITS-1:0] rrot;
  logic [BITS-1:0] cr_chain [0:LOGH];

  bitmat_idx_swap #(.BITS(BITS), .A(LOGD - 1), .B(2*LOGD - 1)) u_qswap (
    .din (in_data),
    .dout(qswap)
  );
  bitmat_row_rot #(.DIM(DIM)) u_rrot (
    .din (qswap),
    .dout(rrot)
  );
  assign cr_chain[0] = rrot;
  for (genvar j = 0; j < LOGH; j++) begin : g_cstage
    bitmat_col_stage #(.DIM(DIM), .SEL(LOGH - 1 - j)) u_stage (
      .din (cr_chain[j]),
      .dout(cr_chain[j+1])
    );
  end

  logic [BITS-1:0] sel_result;
  assign sel_result = mode ? cr_chain[LOGH] : xp_chain[LOGD];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_data <= sel_result;
    end
  end

  // Observation wire: input column 0.
  logic [DIM-1:0] col0_bits;
  for (genvar r = 0; r < DIM; r++) begin : g_c0
    assign col0_bits[r] = in_data[r*DIM];
  end

  p_valid_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_valid_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  p_data_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_data));
  p_xpose_corner_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !mode) |=> (out_data[1] == $past(in_data[DIM])));
  p_ones_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> ($countones(out_data) == $past($countones(in_data))));
  p_col0_row0_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode) |=> ($countones(out_data[DIM-1:0]) == $past($countones(col0_bits))));
endmodule

// File: tb/sim_bitmat_permuter.sv
module sim_bitmat_permuter;
  localparam int CLK_PERIOD = 10;
  localparam int DIM = 16;
  localparam int BITS = DIM * DIM;
  localparam int HALF = DIM / 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic mode = 1'b0;
  logic [BITS-1:0] in_data = '0;
  logic out_valid;
  logic [BITS-1:0] out_data;

  int checks = 0;
  int errors = 0;

  bitmat_permuter #(.DIM(DIM)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode),
    .in_data(in_data), .out_valid(out_valid), .out_data(out_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [BITS-1:0] act,
                     input logic [BITS-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [BITS-1:0] ref_xpose(input logic [BITS-1:0] m);
    logic [BITS-1:0] o;
    for (int r = 0; r < DIM; r++)
      for (int c = 0; c < DIM; c++)
        o[c*DIM+r] = m[r*DIM+c];
    return o;
  endfunction

  // Step-by-step model, each step pushing elements to their destination.
  function automatic logic [BITS-1:0] ref_group(input logic [BITS-1:0] m);
    logic [BITS-1:0] a, b, o;
    for (int r = 0; r < DIM; r++)
      for (int c = 0; c < DIM; c++)
        if ((r >= HALF) != (c >= HALF)) a[(r^HALF)*DIM + (c^HALF)] = m[r*DIM+c];
        else a[r*DIM+c] = m[r*DIM+c];
    for (int r = 0; r < DIM; r++)
      for (int c = 0; c < DIM; c++)
        b[r*DIM + (c+r)%DIM] = a[r*DIM+c];
    for (int r = 0; r < DIM; r++)
      for (int c = 0; c < DIM; c++) begin
        int base = (r / HALF) * HALF;
        int p = r % HALF;
        int n = c % HALF;
        o[(base + (p - n + HALF) % HALF)*DIM + c] = b[r*DIM+c];
      end
    return o;
  endfunction

  function automatic int dest_row(input int c);
    return ((HALF - c % HALF) % HALF) + HALF * (c / HALF);
  endfunction

  function automatic logic [BITS-1:0] rnd_word();
    logic [BITS-1:0] w;
    for (int i = 0; i < BITS/32; i++) w[i*32 +: 32] = $urandom;
    return w;
  endfunction

  task automatic apply(input logic md, input logic [BITS-1:0] d);
    @(negedge clk);
    mode = md; in_data = d; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic t_reset();
    chk(out_valid == 1'b0, "R1 valid in reset", {255'b0, out_valid}, '0);
    chk(out_data == '0, "R1 data in reset", out_data, '0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0 && out_data == '0, "R1 idle after reset", out_data, '0);
  endtask

  task automatic t_latency();
    logic [BITS-1:0] d = rnd_word();
    logic [BITS-1:0] held;
    apply(1'b0, d);
    chk(out_valid == 1'b1, "R2 valid one cycle later", {255'b0, out_valid}, 1);
    held = out_data;
    in_data = rnd_word(); mode = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R2 valid drops", {255'b0, out_valid}, 0);
    chk(out_data == held, "R2 data held", out_data, held);
  endtask

  task automatic t_xpose();
    logic [BITS-1:0] d;
    logic [BITS-1:0] first;
    d = '0; d[2*DIM+5] = 1'b1;
    apply(1'b0, d);
    chk(out_data == ref_xpose(d), "R3 single bit", out_data, ref_xpose(d));
    for (int i = 0; i < 4; i++) begin
      d = rnd_word();
      apply(1'b0, d);
      chk(out_data == ref_xpose(d), "R3 random", out_data, ref_xpose(d));
    end
    d = {BITS/16{16'h00FF}};
    apply(1'b0, d);
    chk(out_data == ref_xpose(d), "R3 half columns", out_data, ref_xpose(d));
    d = rnd_word();
    apply(1'b0, d);
    first = out_data;
    apply(1'b0, first);
    chk(out_data == d, "R8 double transpose", out_data, d);
  endtask

  task automatic t_columns();
    logic [BITS-1:0] d, e;
    for (int c = 0; c < DIM; c++) begin
      d = '0; e = '0;
      for (int r = 0; r < DIM; r++) d[r*DIM+c] = 1'b1;
      e[dest_row(c)*DIM +: DIM] = '1;
      apply(1'b1, d);
      chk(out_data == e, "R4 column to row", out_data, e);
    end
    for (int i = 0; i < BITS; i++) begin
      int row_hit;
      d = '0; d[i] = 1'b1;
      apply(1'b1, d);
      row_hit = -1;
      for (int r = 0; r < DIM; r++) if (out_data[r*DIM +: DIM] != '0) row_hit = r;
      chk($countones(out_data) == 1 && row_hit == dest_row(i % DIM),
          "R4 bit exactly once", out_data, ref_group(d));
    end
  endtask

  task automatic t_steps();
    logic [BITS-1:0] d;
    d = '0;
    for (int r = 0; r < HALF; r++) d[r*DIM + HALF + (r % HALF)] = 1'b1;
    for (int r = HALF; r < DIM; r++) d[r*DIM + (r % 3)] = 1'b1;
    apply(1'b1, d);
    chk(out_data == ref_group(d), "R5 off-diagonal quadrants", out_data, ref_group(d));
    d = '0;
    for (int r = 0; r < DIM; r++) d[r*DIM + 3] = (r % 2 == 0);
    apply(1'b1, d);
    chk(out_data == ref_group(d), "R6 row rotate", out_data, ref_group(d));
    for (int i = 0; i < 3; i++) begin
      d = rnd_word();
      apply(1'b1, d);
      chk(out_data == ref_group(d), "R7 column rotate dense", out_data, ref_group(d));
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD/4);
    t_reset();
    t_latency();
    t_xpose();
    t_columns();
    t_steps();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule